// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Product/Quotient Register Pair

This block computes 32-bit integer multiplies and divides, signed or unsigned, over several clock cycles and keeps the outcome in a dedicated register pair. In this design the upper half is called HI and the lower half is called LO. A command is a two-bit operation code plus two operands. It is accepted on any cycle in which the unit is idle. The unit then runs one shift-and-add or restoring-subtract step per clock until all operand bits have been processed. It raises `busy` for the whole run.

A multiply leaves its double-width product in the pair, with the upper word in HI and the lower word in LO. A divide leaves the remainder in HI and the quotient in LO. Both registers are always visible on two read ports. The ports change only on the clock edge where a run completes. A consumer that must see the newest result waits for `busy` to go low.

Top module: `muldiv_unit`

## Requirements
- R1: After synchronous reset, `busy` is low and both `hi_out` and `lo_out` read zero.
- R2: A command presented while `busy` is low is accepted at that clock edge. `busy` is then high for exactly WIDTH cycles, and the result appears on the read ports at the edge where `busy` falls.
- R3: Operation code 2'b00 (signed multiply) places the two's-complement double-width product in {`hi_out`, `lo_out`}.
- R4: Operation code 2'b01 (unsigned multiply) places the natural-number double-width product in {`hi_out`, `lo_out`}.
- R5: Operation code 2'b10 (signed divide) places in `lo_out` the quotient truncated toward zero, and in `hi_out` a remainder that carries the dividend's sign.
- R6: Operation code 2'b11 (unsigned divide) places the natural-number quotient in `lo_out` and the remainder in `hi_out`.
- R7: A divide by a zero divisor, signed or unsigned, completes normally. It leaves all ones in `lo_out` and the unchanged dividend in `hi_out`.
- R8: A command presented while `busy` is high is dropped entirely. It starts no run and does not change the result of the run in progress.
- R9: `hi_out` and `lo_out` hold their values on every cycle except the completion edge. They therefore hold through a run and during idle cycles.
- R10: No operation raises an error. The most-negative operand wraps silently: signed 0x80000000 / 0xFFFFFFFF gives quotient 0x80000000 and remainder 0. Signed 0x80000000 x 0x80000000 gives 0x40000000_00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| cmd_a | input | WIDTH | Multiplicand or dividend |
| cmd_b | input | WIDTH | Multiplier or divisor |
| busy | output | 1 | A run is in progress |
| hi_out | output | WIDTH | Current HI: product upper word or remainder |
| lo_out | output | WIDTH | Current LO: product lower word or quotient |

## Verification
Two events can land on one edge: the final step of a run writing HI/LO, and a new command that arrives in that same last busy cycle. The bench drives a deliberately different command in exactly the last busy cycle of a run. It then requires the scoreboard to receive only the first run's result, and requires `busy` to stay low afterwards. A companion case issues the next command on the very first idle cycle after completion. For that case the bench requires both the previous result on the read ports and a correct second result 32 cycles later.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        MD_MUL  = 2'd0,
        MD_MULU = 2'd1,
        MD_DIV  = 2'd2,
        MD_DIVU = 2'd3
    } md_op_e;

    // Per-run context captured when a command is accepted
    typedef struct packed {
        logic is_div;
        logic neg_main;   // negate product or quotient at the end
        logic neg_rem;    // negate remainder at the end
        logic div_zero;   // divisor was zero
    } md_ctx_t;

    function automatic logic op_is_div(md_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_signed(md_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
    parameter int STEPS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic last_step
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    logic [CW-1:0] step_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            step_cnt <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                step_cnt <= '0;
            end
        end else if (step_cnt == LAST) begin
            busy     <= 1'b0;
            step_cnt <= '0;
        end else begin
            step_cnt <= step_cnt + 1'b1;
        end
    end

    assign last_step = busy && (step_cnt == LAST);

endmodule

// File: rtl/muldiv_mul_step.sv
module muldiv_mul_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
        nxt_hi = sum[W:1];
        nxt_lo = {sum[0], acc_lo[W-1:1]};
    end

endmodule

// File: rtl/muldiv_div_step.sv
module muldiv_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] nxt_rem,
    output logic [W-1:0] nxt_quo
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvsr};
        fits    = ~diff[W];
        nxt_rem = fits ? diff[W-1:0] : shifted[W-1:0];
        nxt_quo = {quo[W-2:0], fits};
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_a,
    input  logic [WIDTH-1:0] cmd_b,
    output logic             busy,
    output logic [WIDTH-1:0] hi_out,
    output logic [WIDTH-1:0] lo_out
);
    localparam int DW = 2 * WIDTH;

    md_op_e          op;
    md_ctx_t         ctx;
    logic            start;
    logic            last_step;
    logic            a_neg, b_neg;
    logic [WIDTH-1:0] mag_a, mag_b;
    logic [WIDTH-1:0] acc_hi, acc_lo, opnd;
    logic [WIDTH-1:0] mul_hi, mul_lo, div_rem, div_quo;
    logic [WIDTH-1:0] step_hi, step_lo;
    logic [WIDTH-1:0] hi_q, lo_q;
    logic [WIDTH-1:0] fin_hi, fin_lo;
    logic [DW-1:0]    prod;

    assign op    = md_op_e'(cmd_op);
    assign start = cmd_valid && !busy;

    // Operand magnitudes for the unsigned core loop
    always_comb begin
        a_neg = op_is_signed(op) && cmd_a[WIDTH-1];
        b_neg = op_is_signed(op) && cmd_b[WIDTH-1];
        mag_a = a_neg ? -cmd_a : cmd_a;
        mag_b = b_neg ? -cmd_b : cmd_b;
    end

    muldiv_seq #(.STEPS(WIDTH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .busy      (busy),
        .last_step (last_step)
    );

    muldiv_mul_step #(.W(WIDTH)) u_mul (
        .acc_hi (acc_hi),
        .acc_lo (acc_lo),
        .mcand  (opnd),
        .nxt_hi (mul_hi),
        .nxt_lo (mul_lo)
    );

    muldiv_div_step #(.W(WIDTH)) u_div (
        .rem     (acc_hi),
        .quo     (acc_lo),
        .dvsr    (opnd),
        .nxt_rem (div_rem),
        .nxt_quo (div_quo)
    );

    assign step_hi = ctx.is_div ? div_rem : mul_hi;
    assign step_lo = ctx.is_div ? div_quo : mul_lo;

    // Sign correction and zero-divisor fixup applied on the final step
    always_comb begin
        prod = {step_hi, step_lo};
        if (ctx.neg_main && !ctx.is_div) begin
            prod = -prod;
        end
        if (ctx.is_div) begin
            fin_lo = ctx.neg_main ? -step_lo : step_lo;
            fin_hi = ctx.neg_rem  ? -step_hi : step_hi;
            if (ctx.div_zero) begin
                fin_lo = '1;
            end
        end else begin
            fin_hi = prod[DW-1:WIDTH];
            fin_lo = prod[WIDTH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi <= '0;
            acc_lo <= '0;
            opnd   <= '0;
            ctx    <= '0;
        end else if (start) begin
            acc_hi       <= '0;
            acc_lo       <= op_is_div(op) ? mag_a : mag_b;
            opnd         <= op_is_div(op) ? mag_b : mag_a;
            ctx.is_div   <= op_is_div(op);
            ctx.neg_main <= a_neg ^ b_neg;
            ctx.neg_rem  <= a_neg;
            ctx.div_zero <= op_is_div(op) && (cmd_b == '0);
        end else if (busy) begin
            acc_hi <= step_hi;
            acc_lo <= step_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (last_step) begin
            hi_q <= fin_hi;
            lo_q <= fin_lo;
        end
    end

    assign hi_out = hi_q;
    assign lo_out = lo_q;

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_valid,
    input logic [1:0]   cmd_op,
    input logic [W-1:0] cmd_a,
    input logic [W-1:0] cmd_b,
    input logic         busy,
    input logic [W-1:0] hi_out,
    input logic [W-1:0] lo_out
);
    logic [15:0]    run_len;
    logic [2*W-1:0] exp_prod;
    logic [W-1:0]   saved_a;
    logic           k_smul, k_umul, k_dzero;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len  <= '0;
            exp_prod <= '0;
            saved_a  <= '0;
            k_smul   <= 1'b0;
            k_umul   <= 1'b0;
            k_dzero  <= 1'b0;
        end else begin
            run_len <= busy ? run_len + 1'b1 : '0;
            if (cmd_valid && !busy) begin
                saved_a <= cmd_a;
                k_smul  <= (cmd_op == 2'd0);
                k_umul  <= (cmd_op == 2'd1);
                k_dzero <= cmd_op[1] && (cmd_b == '0);
                if (cmd_op == 2'd0) begin
                    exp_prod <= $signed({{W{cmd_a[W-1]}}, cmd_a}) * $signed({{W{cmd_b[W-1]}}, cmd_b});
                end else begin
                    exp_prod <= {{W{1'b0}}, cmd_a} * {{W{1'b0}}, cmd_b};
                end
            end
        end
    end

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> busy);

    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == 16'(W)));

    a_r3_signed_product: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && k_smul) |-> ({hi_out, lo_out} == exp_prod));

    a_r4_unsigned_product: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && k_umul) |-> ({hi_out, lo_out} == exp_prod));

    a_r7_div_zero: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && k_dzero) |-> (lo_out == '1 && hi_out == saved_a));

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(hi_out) && $stable(lo_out)));

    a_r9_hold_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy -> ($stable(hi_out) && $stable(lo_out))));

endmodule

bind muldiv_unit muldiv_checker #(.W(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_a     (cmd_a),
    .cmd_b     (cmd_b),
    .busy      (busy),
    .hi_out    (hi_out),
    .lo_out    (lo_out)
);

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 32;

    typedef struct {
        logic [63:0] exp;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_a = '0;
    logic [31:0] cmd_b = '0;
    logic        busy;
    logic [31:0] hi_out, lo_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    sb_item_t sb_q[$];
    logic [31:0] held_hi = '0, held_lo = '0;
    logic        prev_busy = 1'b0;
    int          busy_run = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    muldiv_unit #(.WIDTH(W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_a     (cmd_a),
        .cmd_b     (cmd_b),
        .busy      (busy),
        .hi_out    (hi_out),
        .lo_out    (lo_out)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            2'd0: return 64'(sa * sb);
            2'd1: return {32'b0, a} * {32'b0, b};
            2'd2: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                q = sa / sb;
                r = sa % sb;
                return {r[31:0], q[31:0]};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                return {a % b, a / b};
            end
        endcase
    endfunction

    // Driver: waits for idle, presents one command, queues its expectation
    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
        sb_item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_a     = a;
        cmd_b     = b;
        it.exp = model(op, a, b);
        it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Monitor: compares each completed result against the queue
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                busy_run++;
                check(hi_out == held_hi && lo_out == held_lo, "R9 hold during run",
                      {hi_out, lo_out}, {held_hi, held_lo});
            end
            if (prev_busy && !busy) begin
                check(busy_run == W, "R2 busy length", 64'(busy_run), 64'(W));
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8 unexpected result", {hi_out, lo_out}, '0);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check({hi_out, lo_out} == it.exp, it.req, {hi_out, lo_out}, it.exp);
                end
                held_hi  = hi_out;
                held_lo  = lo_out;
                busy_run = 0;
            end
        end
        prev_busy = busy;
    end

    task automatic drain();
        @(negedge clk);
        while (busy || sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && hi_out == 0 && lo_out == 0, "R1 reset state",
              {31'b0, busy, hi_out}, 64'd0);

        // R3 signed multiply
        issue(2'd0, 32'hFFFF_FFF9, 32'd6, "R3 smul -7*6");
        issue(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 smul -1*-1");
        issue(2'd0, 32'h7FFF_FFFF, 32'd2, "R3 smul max*2");
        // R4 unsigned multiply
        issue(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 umul max*max");
        issue(2'd1, 32'd12345, 32'd6789, "R4 umul small");
        // R5 signed divide
        issue(2'd2, 32'hFFFF_FFF9, 32'd2, "R5 sdiv -7/2");
        issue(2'd2, 32'd7, 32'hFFFF_FFFE, "R5 sdiv 7/-2");
        issue(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R5 sdiv -7/-2");
        // R6 unsigned divide
        issue(2'd3, 32'hFFFF_FFFF, 32'd7, "R6 udiv max/7");
        issue(2'd3, 32'd100, 32'd200, "R6 udiv 100/200");
        // R7 divide by zero
        issue(2'd2, 32'hFFFF_FFFB, 32'd0, "R7 sdiv -5/0");
        issue(2'd3, 32'd9, 32'd0, "R7 udiv 9/0");
        // R10 wrap cases
        issue(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R10 sdiv min/-1");
        issue(2'd0, 32'h8000_0000, 32'h8000_0000, "R10 smul min*min");
        drain();

        // R9 idle hold
        repeat (4) @(negedge clk);
        check(hi_out == held_hi && lo_out == held_lo, "R9 hold while idle",
              {hi_out, lo_out}, {held_hi, held_lo});

        // R8: a command in the last busy cycle is dropped
        issue(2'd1, 32'd3, 32'd5, "R8 run before late command");
        repeat (31) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'd3;
        cmd_a     = 32'd1000;
        cmd_b     = 32'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!busy, "R8 late command started nothing", {63'b0, busy}, 64'd0);
        @(negedge clk);
        check(!busy && sb_q.size() == 0, "R8 still idle", {63'b0, busy}, 64'd0);
        check({hi_out, lo_out} == 64'd15, "R8 result kept", {hi_out, lo_out}, 64'd15);

        // Back-to-back on the first idle cycle
        issue(2'd3, 32'd50, 32'd7, "R2 back-to-back first");
        issue(2'd0, 32'hFFFF_FFFE, 32'd3, "R2 back-to-back second");
        drain();

        finish_run();
    end

endmodule